// File: doc/BRIEF.md
# Two-Wire Register Slave for Clock Output Control

This block is a serial slave on a two-wire bus that keeps a six-entry bank of 8-bit control registers for a clock generator. The master can access one register at a time (byte mode) or a run of consecutive registers (block mode). The block drives the register contents to the clock-control logic as parallel outputs. It also decodes the output-enable bits and the amplitude field into ready-to-use signals.

SCL and SDA are sampled in the system clock domain through a synchronizer. The block detects edges, start conditions and stop conditions from the sampled values. It never drives SDA high. It only pulls the line low, through an open-drain enable, during its own acknowledge slots and its own read-data bits. Clock stretching, 10-bit addressing, general call, packet error checking and arbitration are not handled.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset, registers 0..5 hold 0x04, 0x00, 0xC0, 0x08, 0x06, 0xD8. `regs_o` carries register i in bits [8i+7:8i].
- R2: The block acknowledges only the address byte 0xD6 (write) or 0xD7 (read), i.e. 7-bit address 0x6B. For any other address byte, that byte and every following byte up to the next start or stop are not acknowledged, and no register changes.
- R3: A byte write sends a command byte with bit 7 = 1 and bits 6:0 = register index, then one data byte. It updates that register only. A second data byte in the same transfer is not acknowledged and is discarded.
- R4: A byte read sends command bit 7 = 1 and the index, then a repeated start and the address with the read bit. The block returns that register MSB first, and the master ends with NACK.
- R5: A block write sends command bit 7 = 0 with bits 6:0 = start index, then a count byte, then data bytes. Data bytes are written to rising indices starting at the start index, and every byte is acknowledged.
- R6: A block read sends command bit 7 = 0, then a repeated start and a read address. The block first returns the current content of register 4. It then returns registers from the start index upward while the master acknowledges. After the master's NACK, the block releases SDA.
- R7: A write to an index of 6 or more is acknowledged and changes nothing. A read from such an index returns 0x00.
- R8: A start or stop arriving before the 8th bit of a data byte abandons the transfer, and no register is modified by the partial byte. A new transfer after a repeated start works normally.
- R9: `ref_en_o` = register 0 bit 2. `diff_en_o[0]` = register 2 bit 7 and `diff_en_o[1]` = register 2 bit 6. `amp_mv_o` = 300 + 100 × register 5 bits 6:4 when register 5 bit 7 is 1, and 700 otherwise.
- R10: `sda_oe_o` (1 = pull SDA low) only turns on while SCL is low and never changes while SCL stays high. It is 0 between transfers. Registers change only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| regs_o | output | 48 | Register bank contents, register i at bits [8i+7:8i] |
| ref_en_o | output | 1 | Reference clock output enable |
| diff_en_o | output | 2 | Differential output enables, bit n for output n |
| amp_mv_o | output | 10 | Differential swing in millivolts |

## Verification
The checker watches three properties on every cycle:
- The SDA pull is only switched on while SCL is low and is held steady through every SCL-high phase, so the slave can never create a false start or stop.
- Register contents change only during SCL-low phases.
- The decoded swing stays within 300 to 1000 mV. The reset image of the bank is also checked.

Other behaviour can only be shown by the bench's directed transfers, because it depends on a whole protocol sequence:
- address matching;
- the byte-mode and block-mode split on command bit 7;
- the count byte that leads a block read;
- index walking, and the behaviour past the last register;
- discarding a data byte that a start or stop cuts off.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int REG_W       = 8;
  localparam int AMP_W       = 10;
  localparam int AMP_BASE_MV = 300;
  localparam int AMP_STEP_MV = 100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_WR,
    ST_RD,
    ST_SKIP
  } link_st_e;

  function automatic logic [REG_W-1:0] reg_rst_val(input int idx);
    case (idx)
      0:       return 8'h04;
      1:       return 8'h00;
      2:       return 8'hC0;
      3:       return 8'h08;
      4:       return 8'h06;
      5:       return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_pin_sync.sv
module smb_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s, sda_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA moving while SCL is held high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_pkg::*;
#(
  parameter int         IW       = 7,
  parameter logic [6:0] DEV_ADDR = 7'h6B
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [REG_W-1:0] rd_data_i,
  input  logic [REG_W-1:0] cnt_data_i,
  output logic             sda_oe_o,
  output logic [IW-1:0]    rd_idx_o,
  output logic             wr_en_o,
  output logic [IW-1:0]    wr_idx_o,
  output logic [REG_W-1:0] wr_data_o
);
  link_st_e         state, nxt;
  logic [3:0]       bit_cnt;
  logic [REG_W-1:0] rx_sh, tx_sh;
  logic             ack_slot, byte_mode, mack, sda_oe;
  logic [IW-1:0]    ptr, ptr_inc;

  assign ptr_inc  = (ptr == '1) ? ptr : ptr + IW'(1);
  assign rd_idx_o = ptr;
  assign sda_oe_o = sda_oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      nxt       <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ack_slot  <= 1'b0;
      byte_mode <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      ptr       <= '0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        bit_cnt  <= '0;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_CNT, ST_WR: begin
            if (scl_rise_i && !ack_slot && bit_cnt != 4'd8) begin
              rx_sh   <= {rx_sh[REG_W-2:0], sda_i};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall_i && !ack_slot && bit_cnt == 4'd8) begin
              // full byte in hand: act on it and open the ack slot
              ack_slot <= 1'b1;
              unique case (state)
                ST_ADDR: begin
                  if (rx_sh[7:1] == DEV_ADDR) begin
                    sda_oe <= 1'b1;
                    nxt    <= rx_sh[0] ? ST_RD : ST_CMD;
                  end else begin
                    nxt    <= ST_SKIP;
                  end
                end
                ST_CMD: begin
                  sda_oe    <= 1'b1;
                  byte_mode <= rx_sh[7];
                  ptr       <= rx_sh[IW-1:0];
                  nxt       <= rx_sh[7] ? ST_WR : ST_CNT;
                end
                ST_CNT: begin
                  sda_oe <= 1'b1;
                  nxt    <= ST_WR;
                end
                default: begin
                  sda_oe    <= 1'b1;
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= ptr;
                  wr_data_o <= rx_sh;
                  ptr       <= ptr_inc;
                  nxt       <= byte_mode ? ST_SKIP : ST_WR;
                end
              endcase
            end else if (scl_fall_i && ack_slot) begin
              ack_slot <= 1'b0;
              bit_cnt  <= '0;
              state    <= nxt;
              if (nxt == ST_RD) begin
                if (byte_mode) begin
                  sda_oe <= ~rd_data_i[7];
                  tx_sh  <= {rd_data_i[REG_W-2:0], 1'b0};
                  ptr    <= ptr_inc;
                end else begin
                  sda_oe <= ~cnt_data_i[7];
                  tx_sh  <= {cnt_data_i[REG_W-2:0], 1'b0};
                end
                bit_cnt <= 4'd1;
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_RD: begin
            if (scl_fall_i) begin
              if (bit_cnt < 4'd8) begin
                sda_oe  <= ~tx_sh[7];
                tx_sh   <= {tx_sh[REG_W-2:0], 1'b0};
                bit_cnt <= bit_cnt + 4'd1;
              end else if (bit_cnt == 4'd8) begin
                sda_oe  <= 1'b0;
                bit_cnt <= 4'd9;
              end else if (mack && !byte_mode) begin
                sda_oe  <= ~rd_data_i[7];
                tx_sh   <= {rd_data_i[REG_W-2:0], 1'b0};
                ptr     <= ptr_inc;
                bit_cnt <= 4'd1;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_SKIP;
              end
            end else if (scl_rise_i && bit_cnt == 4'd9) begin
              mack <= ~sda_i;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_pkg::*;
#(
  parameter int NREG    = 6,
  parameter int IW      = 7,
  parameter int CNT_IDX = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IW-1:0]         wr_idx_i,
  input  logic [REG_W-1:0]      wr_data_i,
  input  logic [IW-1:0]         rd_idx_i,
  output logic [REG_W-1:0]      rd_data_o,
  output logic [REG_W-1:0]      cnt_data_o,
  output logic [NREG*REG_W-1:0] regs_o
);
  logic [REG_W-1:0] regs [NREG];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                regs[i] <= reg_rst_val(i);
        else if (wr_en_i && wr_idx_i == IW'(i))     regs[i] <= wr_data_i;
      end
      assign regs_o[i*REG_W +: REG_W] = regs[i];
    end
  endgenerate

  // unimplemented indices read as zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_idx_i == IW'(i)) rd_data_o = regs[i];
  end

  assign cnt_data_o = regs[CNT_IDX];
endmodule

// File: rtl/smb_out_decode.sv
module smb_out_decode
  import smb_pkg::*;
#(
  parameter int DEF_AMP_MV = 700
) (
  input  logic             ref_bit_i,
  input  logic             diff0_bit_i,
  input  logic             diff1_bit_i,
  input  logic             amp_sel_i,
  input  logic [2:0]       amp_code_i,
  output logic             ref_en_o,
  output logic [1:0]       diff_en_o,
  output logic [AMP_W-1:0] amp_mv_o
);
  assign ref_en_o  = ref_bit_i;
  assign diff_en_o = {diff1_bit_i, diff0_bit_i};
  assign amp_mv_o  = amp_sel_i
                   ? AMP_W'(AMP_BASE_MV) + AMP_W'(amp_code_i) * AMP_W'(AMP_STEP_MV)
                   : AMP_W'(DEF_AMP_MV);
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter int         NREG        = 6,
  parameter int         IW          = 7,
  parameter int         CNT_IDX     = 4,
  parameter int         SYNC_STAGES = 2,
  parameter int         DEF_AMP_MV  = 700,
  parameter logic [6:0] DEV_ADDR    = 7'h6B
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NREG*REG_W-1:0] regs_o,
  output logic                  ref_en_o,
  output logic [1:0]            diff_en_o,
  output logic [AMP_W-1:0]      amp_mv_o
);
  localparam int CTL_REF  = 0;
  localparam int CTL_DIFF = 2;
  localparam int CTL_AMP  = 5;

  logic             sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic [REG_W-1:0] rd_data, cnt_data, wr_data;
  logic [IW-1:0]    rd_idx, wr_idx;
  logic             wr_en;

  smb_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  smb_link #(.IW(IW), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk_i, .rst_ni, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c),
    .rd_data_i(rd_data), .cnt_data_i(cnt_data),
    .sda_oe_o, .rd_idx_o(rd_idx),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  smb_regbank #(.NREG(NREG), .IW(IW), .CNT_IDX(CNT_IDX)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .cnt_data_o(cnt_data),
    .regs_o
  );

  smb_out_decode #(.DEF_AMP_MV(DEF_AMP_MV)) u_dec (
    .ref_bit_i  (regs_o[CTL_REF*REG_W + 2]),
    .diff0_bit_i(regs_o[CTL_DIFF*REG_W + 7]),
    .diff1_bit_i(regs_o[CTL_DIFF*REG_W + 6]),
    .amp_sel_i  (regs_o[CTL_AMP*REG_W + 7]),
    .amp_code_i (regs_o[CTL_AMP*REG_W + 4 +: 3]),
    .ref_en_o, .diff_en_o, .amp_mv_o
  );
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk
  import smb_pkg::*;
#(
  parameter int NREG = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_i,
  input logic                  sda_oe_o,
  input logic [NREG*REG_W-1:0] regs_o,
  input logic [AMP_W-1:0]      amp_mv_o
);
  logic [NREG*REG_W-1:0] rst_img;
  logic                  rst_seen;

  always_comb begin
    for (int i = 0; i < NREG; i++) rst_img[i*REG_W +: REG_W] = reg_rst_val(i);
  end

  always_ff @(posedge clk_i) begin
    rst_seen <= !rst_ni;
    // R1
    if (!rst_ni && rst_seen)
      a_r1_reset_image: assert (regs_o == rst_img);
  end

  a_r10_pull_on_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  a_r10_steady_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

  a_r10_regs_on_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> !scl_i);

  a_r9_amp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_mv_o >= AMP_W'(300) && amp_mv_o <= AMP_W'(1000));
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.NREG(NREG)) u_chk (
  .clk_i, .rst_ni, .scl_i, .sda_oe_o, .regs_o, .amp_mv_o
);

// File: tb/tb_smb_reg_slave.sv
module tb_smb_reg_slave;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_lo = 1'b0;
  logic        sda_oe_o, ref_en_o;
  logic [47:0] regs_o;
  logic [1:0]  diff_en_o;
  logic [9:0]  amp_mv_o;
  logic        sda_bus;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mdl [6];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #5 clk = ~clk;
  assign sda_bus = ~(m_lo | sda_oe_o);

  smb_reg_slave dut (
    .clk_i(clk), .rst_ni, .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o, .regs_o, .ref_en_o, .diff_en_o, .amp_mv_o
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mdl_flat();
    logic [47:0] f;
    for (int i = 0; i < 6; i++) f[i*8 +: 8] = mdl[i];
    return f;
  endfunction

  function automatic logic [7:0] mdl_rd(input int idx);
    return (idx < 6) ? mdl[idx] : 8'h00;
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    m_lo = ~b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    m_lo = 1'b0; wq(); m_scl = 1'b1; wq(); b = sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic cond_start();
    m_lo = 1'b0; wq(); m_scl = 1'b1; wq(); m_lo = 1'b1; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic cond_stop();
    m_lo = 1'b1; wq(); m_scl = 1'b1; wq(); m_lo = 1'b0; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(~give_ack);
  endtask

  task automatic byte_write(input logic [6:0] idx, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    cond_start();
    send_byte(8'hD6, a0); send_byte({1'b1, idx}, a1); send_byte(d, a2);
    cond_stop();
    ok = a0 & a1 & a2;
    if (idx < 6) mdl[idx] = d;
  endtask

  task automatic byte_read(input logic [6:0] idx, output logic [7:0] d);
    logic a;
    cond_start();
    send_byte(8'hD6, a); send_byte({1'b1, idx}, a);
    cond_start();
    send_byte(8'hD7, a);
    recv_byte(1'b0, d);
    cond_stop();
  endtask

  task automatic blk_write(input logic [6:0] idx, input int n, output logic ok);
    logic a;
    cond_start();
    send_byte(8'hD6, a); ok = a;
    send_byte({1'b0, idx}, a); ok &= a;
    send_byte(8'(n), a); ok &= a;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); ok &= a;
      if (int'(idx) + i < 6) mdl[int'(idx) + i] = wbuf[i];
    end
    cond_stop();
  endtask

  task automatic blk_read(input logic [6:0] idx, input int n, output logic [7:0] cnt);
    logic a;
    cond_start();
    send_byte(8'hD6, a); send_byte({1'b0, idx}, a);
    cond_start();
    send_byte(8'hD7, a);
    recv_byte(n > 0, cnt);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
    cond_stop();
  endtask

  task automatic t_reset();
    chk("R1 reset bank", 64'(regs_o), 64'(mdl_flat()));
    chk("R9 reset ref_en", 64'(ref_en_o), 64'(1));
    chk("R9 reset diff_en", 64'(diff_en_o), 64'(2'b11));
    chk("R9 reset amp", 64'(amp_mv_o), 64'(800));
    chk("R10 idle release", 64'(sda_oe_o), 64'(0));
  endtask

  task automatic t_byte_access();
    logic ok, a;
    logic [7:0] d;
    byte_write(7'd1, 8'h5A, ok);
    chk("R3 byte write acks", 64'(ok), 64'(1));
    chk("R3 byte write bank", 64'(regs_o), 64'(mdl_flat()));
    byte_read(7'd1, d);
    chk("R4 byte read data", 64'(d), 64'(8'h5A));
    byte_read(7'd2, d);
    chk("R4 byte read reg2", 64'(d), 64'(mdl[2]));
    chk("R10 release after read", 64'(sda_oe_o), 64'(0));
    cond_start();
    send_byte(8'hD6, a); send_byte(8'h83, a);
    send_byte(8'h11, a);
    chk("R3 first data ack", 64'(a), 64'(1));
    send_byte(8'h22, a);
    chk("R3 second data nack", 64'(a), 64'(0));
    cond_stop();
    mdl[3] = 8'h11;
    chk("R3 only one register", 64'(regs_o), 64'(mdl_flat()));
  endtask

  task automatic t_block_write();
    logic ok;
    wbuf[0] = 8'h00; wbuf[1] = 8'h12; wbuf[2] = 8'h3F;
    blk_write(7'd0, 3, ok);
    chk("R5 block write acks", 64'(ok), 64'(1));
    chk("R5 block write bank", 64'(regs_o), 64'(mdl_flat()));
    chk("R9 ref_en off", 64'(ref_en_o), 64'(0));
    chk("R9 diff_en off", 64'(diff_en_o), 64'(0));
    wbuf[0] = 8'h30;
    blk_write(7'd5, 1, ok);
    chk("R9 default amp", 64'(amp_mv_o), 64'(700));
    byte_write(7'd5, 8'hF0, ok);
    chk("R9 amp max", 64'(amp_mv_o), 64'(1000));
    byte_write(7'd5, 8'h80, ok);
    chk("R9 amp min", 64'(amp_mv_o), 64'(300));
    byte_write(7'd2, 8'h80, ok);
    chk("R9 diff0 only", 64'(diff_en_o), 64'(2'b01));
  endtask

  task automatic t_block_read();
    logic ok;
    logic [7:0] c;
    blk_read(7'd1, 3, c);
    chk("R6 count byte", 64'(c), 64'(mdl[4]));
    for (int i = 0; i < 3; i++) chk("R6 block data", 64'(rbuf[i]), 64'(mdl[1 + i]));
    chk("R6 release after nack", 64'(sda_oe_o), 64'(0));
    byte_write(7'd4, 8'h02, ok);
    blk_read(7'd0, 2, c);
    chk("R6 count follows reg4", 64'(c), 64'(8'h02));
    chk("R6 data0", 64'(rbuf[0]), 64'(mdl[0]));
    chk("R6 data1", 64'(rbuf[1]), 64'(mdl[1]));
  endtask

  task automatic t_out_of_range();
    logic ok;
    logic [7:0] d, c;
    byte_write(7'd7, 8'h77, ok);
    chk("R7 far write acked", 64'(ok), 64'(1));
    chk("R7 far write no effect", 64'(regs_o), 64'(mdl_flat()));
    byte_read(7'd7, d);
    chk("R7 far read zero", 64'(d), 64'(0));
    blk_read(7'd4, 3, c);
    chk("R7 walk reg4", 64'(rbuf[0]), 64'(mdl[4]));
    chk("R7 walk reg5", 64'(rbuf[1]), 64'(mdl[5]));
    chk("R7 walk past end", 64'(rbuf[2]), 64'(mdl_rd(6)));
  endtask

  task automatic t_bad_addr();
    logic a;
    cond_start();
    send_byte(8'hA0, a);
    chk("R2 foreign address nack", 64'(a), 64'(0));
    send_byte(8'h81, a);
    chk("R2 following byte nack", 64'(a), 64'(0));
    send_byte(8'hEE, a);
    cond_stop();
    chk("R2 bank untouched", 64'(regs_o), 64'(mdl_flat()));
    cond_start();
    send_byte(8'hD6, a);
    chk("R2 own address ack", 64'(a), 64'(1));
    cond_stop();
  endtask

  task automatic t_abort();
    logic a;
    cond_start();
    send_byte(8'hD6, a); send_byte(8'h02, a); send_byte(8'h01, a);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    cond_stop();
    chk("R8 stop mid byte", 64'(regs_o), 64'(mdl_flat()));
    cond_start();
    send_byte(8'hD6, a); send_byte(8'h81, a);
    for (int i = 0; i < 3; i++) bit_out(1'b0);
    cond_start();
    chk("R8 start mid byte", 64'(regs_o), 64'(mdl_flat()));
    send_byte(8'hD6, a); send_byte(8'h81, a); send_byte(8'h4C, a);
    cond_stop();
    mdl[1] = 8'h4C;
    chk("R8 recovery write", 64'(regs_o), 64'(mdl_flat()));
    chk("R10 released at end", 64'(sda_oe_o), 64'(0));
  endtask

  initial begin
    for (int i = 0; i < 6; i++) mdl[i] = 8'h00;
    mdl[0] = 8'h04; mdl[2] = 8'hC0; mdl[3] = 8'h08; mdl[4] = 8'h06; mdl[5] = 8'hD8;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_byte_access();
    t_block_write();
    t_block_read();
    t_out_of_range();
    t_bad_addr();
    t_abort();
    summary();
  end
endmodule